// File: doc/BRIEF.md
# Multi-Format TDM Audio Serial Receiver

This block is the receive half of a serial audio port that runs as a clock slave. An external source drives the bit clock, the frame clock and one serial data line. The block oversamples all three in the system clock domain. Each input can be inverted by a configuration bit. On every rising edge of the effective bit clock it takes one data bit. It finds frame boundaries from a chosen edge of the effective frame clock, and the alignment rule depends on the selected framing format: Philips, left-justified, right-justified or PCM short-frame.

A frame holds an even number of slots: two for plain stereo, up to eight for TDM. Each slot is 16 or 32 bits wide and carries a 16-, 24- or 32-bit sample. A per-slot enable mask decides which slots are stored. Each stored sample goes into a receive FIFO as a 32-bit word, left-justified with zero fill below it. The FIFO has a show-ahead read port, an above-level flag, a full flag and a sticky overflow flag. A frame edge that arrives before the current frame has finished realigns the slot counter and raises a sticky sync-error flag.

The framer is a three-state machine. HUNT waits for the first frame edge. In the one-bit-delayed formats (Philips and PCM) that edge moves it to ARM, and the next bit moves it to RUN. In the undelayed formats (left- and right-justified) the edge moves HUNT straight to RUN. RUN is left only through reset.

Top module: `tdm_rx_deser`

## Requirements
- R1: After reset, rd_valid, lvl_above, fifo_full, ovf_flag and sync_err are all 0.
- R2: Data is taken on the rising edge of the effective bit clock, MSB first. In left-justified format (cfg_fmt=1) and right-justified format (cfg_fmt=2), the bit taken at the clock edge where the selected frame-clock edge is first seen is bit 0 of slot 0.
- R3: In Philips format (cfg_fmt=0) and PCM format (cfg_fmt=3), bit 0 of slot 0 is the bit taken one bit-clock later than the frame edge.
- R4: In right-justified format, only the last depth bits of each slot are captured. In the other formats, the first depth bits are captured.
- R5: The slot length is 32 bits when cfg_wide_slot=1 and 16 bits otherwise. cfg_depth selects the depth: 0 gives 16 bits, 1 gives 24 bits, 2 or 3 give 32 bits. A depth above the slot length is clamped to the slot length. The FIFO word is the sample shifted left by 32 minus depth, so its low bits are zero.
- R6: A frame has cfg_nslot slots. Bit k of cfg_slot_en enables slot k, and a disabled slot writes nothing. After the last slot, the counter wraps to slot 0 without needing a new frame edge.
- R7: rd_data shows the oldest word while rd_valid=1. A one-cycle rd_en pulse removes it, and rd_en is ignored when the FIFO is empty. lvl_above=1 exactly when the occupancy is greater than cfg_level. fifo_full=1 exactly when the occupancy equals the FIFO depth.
- R8: A sample that completes while the FIFO is full is dropped and sets ovf_flag. ovf_flag stays set until ovf_clr=1.
- R9: A frame edge that lands at any slot position other than slot 0, bit 0 restarts the frame at slot 0, drops the partial slot and sets sync_err. sync_err stays set until sync_clr=1. An on-time frame edge never sets it.
- R10: cfg_bclk_inv and cfg_fclk_inv invert the incoming clocks before use. cfg_start_rise=1 makes a rising edge of the effective frame clock the frame start, and 0 makes it a falling edge. The stored previous frame-clock level resets to 0.
- R11: Bits that arrive before the first frame edge after reset are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_in | input | 1 | External bit clock |
| fclk_in | input | 1 | External frame clock |
| sdata_in | input | 1 | Serial data line |
| cfg_fmt | input | 2 | Framing format: 0 Philips, 1 left-justified, 2 right-justified, 3 PCM |
| cfg_depth | input | 2 | Sample depth code |
| cfg_wide_slot | input | 1 | 1 selects 32-bit slots, 0 selects 16-bit slots |
| cfg_nslot | input | 4 | Slots per frame (even, 2 to MAX_SLOTS) |
| cfg_slot_en | input | 8 | Per-slot capture enable |
| cfg_bclk_inv | input | 1 | Invert the incoming bit clock |
| cfg_fclk_inv | input | 1 | Invert the incoming frame clock |
| cfg_start_rise | input | 1 | Frame starts on a rising (1) or falling (0) effective frame-clock edge |
| cfg_level | input | 4 | Occupancy level for lvl_above |
| rd_en | input | 1 | Pop the oldest FIFO word |
| ovf_clr | input | 1 | Clear ovf_flag |
| sync_clr | input | 1 | Clear sync_err |
| rd_data | output | 32 | Oldest FIFO word |
| rd_valid | output | 1 | FIFO holds at least one word |
| lvl_above | output | 1 | Occupancy greater than cfg_level |
| fifo_full | output | 1 | FIFO full |
| ovf_flag | output | 1 | Sticky overflow |
| sync_err | output | 1 | Sticky early-frame error |

## Verification
The bench aims at these corner cases:

- **Philips/PCM delay.** A design that mishandled the one-bit delay would shift every sample by one bit.
- **Right-justified capture.** Taking the leading bits instead of the trailing ones would make the 24-bit samples wrong.
- **Clamping and masking.** With a 32-bit depth code on 16-bit slots and a sparse eight-slot mask, a missing clamp would corrupt every sample and a bad mask decode would change which slots are stored.
- **Early frame edge.** The bench sends a truncated frame followed by an early edge. A design that kept a partial slot, or never flagged the error, would show an extra word or a clear sync_err.
- **Overflow, empty read and inversion.** Overfilling the FIFO, reading it while empty, and inverting both clocks catch a flag that does not stick, a pointer that moves on an empty read, and an inversion applied to the wrong signal.

// File: rtl/tdmrx_pkg.sv
package tdmrx_pkg;

    localparam int RX_WORD = 32;

    typedef enum logic [1:0] {
        FMT_PHILIPS = 2'd0,
        FMT_LEFT    = 2'd1,
        FMT_RIGHT   = 2'd2,
        FMT_PCM     = 2'd3
    } rx_fmt_e;

    typedef enum logic [1:0] {
        FR_HUNT = 2'd0,
        FR_ARM  = 2'd1,
        FR_RUN  = 2'd2
    } fr_state_e;

    // depth code to bit count
    function automatic logic [5:0] depth_of(input logic [1:0] code);
        logic [5:0] d;
        case (code)
            2'd0:    d = 6'd16;
            2'd1:    d = 6'd24;
            default: d = 6'd32;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/tdmrx_sync.sv
module tdmrx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_raw,
    input  logic fclk_raw,
    input  logic sd_raw,
    input  logic inv_b,
    input  logic inv_f,
    output logic bit_stb,
    output logic bit_sd,
    output logic bit_fs
);

    logic [STAGES-1:0] b_sh;
    logic [STAGES-1:0] f_sh;
    logic [STAGES-1:0] d_sh;
    logic              b_last;
    logic              b_eff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_sh   <= '0;
            f_sh   <= '0;
            d_sh   <= '0;
            b_last <= 1'b1;
        end else begin
            b_sh   <= {b_sh[STAGES-2:0], bclk_raw};
            f_sh   <= {f_sh[STAGES-2:0], fclk_raw};
            d_sh   <= {d_sh[STAGES-2:0], sd_raw};
            b_last <= b_eff;
        end
    end

    always_comb begin
        b_eff   = b_sh[STAGES-1] ^ inv_b;
        bit_stb = b_eff & ~b_last;
        bit_sd  = d_sh[STAGES-1];
        bit_fs  = f_sh[STAGES-1] ^ inv_f;
    end

    // R2: one data bit per effective rising edge, never two in a row
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |=> !bit_stb);

endmodule

// File: rtl/tdmrx_framer.sv
module tdmrx_framer
    import tdmrx_pkg::*;
#(
    parameter int MAX_SLOTS = 8,
    localparam int SLW = $clog2(MAX_SLOTS),
    localparam int NSW = $clog2(MAX_SLOTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_stb,
    input  logic                 bit_sd,
    input  logic                 bit_fs,
    input  logic [1:0]           cfg_fmt,
    input  logic [1:0]           cfg_depth,
    input  logic                 cfg_wide,
    input  logic [NSW-1:0]       cfg_nslot,
    input  logic [MAX_SLOTS-1:0] cfg_slot_en,
    input  logic                 cfg_start_rise,
    output logic                 push,
    output logic [RX_WORD-1:0]   push_word,
    output logic                 serr_set
);

    fr_state_e          st_q, st_d;
    logic               fs_prev, pend_q;
    logic [SLW-1:0]     slot_q, cur_slot;
    logic [4:0]         bit_q, cur_bit;
    logic [RX_WORD-1:0] sh_q, sh_next, word;

    rx_fmt_e    fmt;
    logic       lead, edge_hit, start_now, take;
    logic       capture, last_bit, last_slot;
    logic [5:0] slot_len, dep_raw, dep;

    always_comb begin
        fmt      = rx_fmt_e'(cfg_fmt);
        lead     = (fmt == FMT_PHILIPS) || (fmt == FMT_PCM);
        edge_hit = cfg_start_rise ? (bit_fs & ~fs_prev) : (~bit_fs & fs_prev);
        slot_len = cfg_wide ? 6'd32 : 6'd16;
        dep_raw  = depth_of(cfg_depth);
        dep      = (dep_raw > slot_len) ? slot_len : dep_raw;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FR_HUNT;
        else        st_q <= st_d;
    end

    // next state and frame-start decode
    always_comb begin
        st_d      = st_q;
        start_now = 1'b0;
        unique case (st_q)
            FR_HUNT: begin
                if (bit_stb && edge_hit) st_d = lead ? FR_ARM : FR_RUN;
                start_now = bit_stb & edge_hit & ~lead;
            end
            FR_ARM: begin
                if (bit_stb) st_d = FR_RUN;
                start_now = bit_stb;
            end
            FR_RUN: begin
                start_now = bit_stb & (lead ? pend_q : edge_hit);
            end
            default: st_d = FR_HUNT;
        endcase
    end

    // slot position and capture decode
    always_comb begin
        take      = bit_stb && ((st_q == FR_RUN) || start_now);
        cur_slot  = start_now ? '0 : slot_q;
        cur_bit   = start_now ? '0 : bit_q;
        if (fmt == FMT_RIGHT) capture = ({1'b0, cur_bit} >= (slot_len - dep));
        else                  capture = ({1'b0, cur_bit} < dep);
        last_bit  = ({1'b0, cur_bit} == (slot_len - 6'd1));
        last_slot = ((NSW'(cur_slot) + NSW'(1)) >= cfg_nslot);
        sh_next   = capture ? {sh_q[RX_WORD-2:0], bit_sd} : sh_q;
        word      = sh_next << (6'd32 - dep);
    end

    // position, history and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_prev <= 1'b0;
            pend_q  <= 1'b0;
            slot_q  <= '0;
            bit_q   <= '0;
            sh_q    <= '0;
        end else begin
            if (bit_stb) begin
                fs_prev <= bit_fs;
                pend_q  <= (st_q == FR_RUN) & lead & edge_hit;
            end
            if (take) begin
                sh_q <= sh_next;
                if (last_bit) begin
                    bit_q  <= '0;
                    slot_q <= last_slot ? '0 : SLW'(cur_slot + SLW'(1));
                end else begin
                    bit_q  <= cur_bit + 5'd1;
                    slot_q <= cur_slot;
                end
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            push      <= 1'b0;
            push_word <= '0;
            serr_set  <= 1'b0;
        end else begin
            push      <= take & last_bit & cfg_slot_en[cur_slot];
            push_word <= word;
            serr_set  <= bit_stb & (st_q == FR_RUN) & start_now &
                         ((slot_q != '0) || (bit_q != '0));
        end
    end

    // R11: nothing is written before the framer has locked
    a_r11_push_locked: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (st_q == FR_RUN));

    // R9: a sync error can only be raised while locked
    a_r9_serr_locked: assert property (@(posedge clk) disable iff (!rst_n)
        serr_set |-> (st_q == FR_RUN));

endmodule

// File: rtl/tdmrx_fifo.sv
module tdmrx_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 32,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [W-1:0]  wdata,
    input  logic          rd,
    input  logic          ovf_clr,
    input  logic [CW-1:0] level,
    output logic [W-1:0]  rdata,
    output logic          valid,
    output logic          above,
    output logic          full,
    output logic          ovf
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    logic          do_wr, do_rd;

    always_comb begin
        full  = (count == CW'(DEPTH));
        valid = (count != '0);
        above = (count > level);
        do_wr = wr & ~full;
        do_rd = rd & valid;
        rdata = mem[rptr];
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (do_wr) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
            if (do_rd) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
            count <= count + CW'(do_wr) - CW'(do_rd);
            if (ovf_clr)        ovf <= 1'b0;
            else if (wr && full) ovf <= 1'b1;
        end
    end

    // R8: a write into a full FIFO raises the overflow flag
    a_r8_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && full && !ovf_clr) |=> ovf);

    // R8: overflow stays until cleared
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);

    // R7: occupancy never passes the depth
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R7: a read of an empty FIFO leaves it empty
    a_r7_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !valid && !wr) |=> !valid);

endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser
    import tdmrx_pkg::*;
#(
    parameter int MAX_SLOTS   = 8,
    parameter int FIFO_DEPTH  = 8,
    parameter int SYNC_STAGES = 2,
    localparam int NSW = $clog2(MAX_SLOTS + 1),
    localparam int CW  = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bclk_in,
    input  logic                 fclk_in,
    input  logic                 sdata_in,
    input  logic [1:0]           cfg_fmt,
    input  logic [1:0]           cfg_depth,
    input  logic                 cfg_wide_slot,
    input  logic [NSW-1:0]       cfg_nslot,
    input  logic [MAX_SLOTS-1:0] cfg_slot_en,
    input  logic                 cfg_bclk_inv,
    input  logic                 cfg_fclk_inv,
    input  logic                 cfg_start_rise,
    input  logic [CW-1:0]        cfg_level,
    input  logic                 rd_en,
    input  logic                 ovf_clr,
    input  logic                 sync_clr,
    output logic [RX_WORD-1:0]   rd_data,
    output logic                 rd_valid,
    output logic                 lvl_above,
    output logic                 fifo_full,
    output logic                 ovf_flag,
    output logic                 sync_err
);

    logic               bit_stb, bit_sd, bit_fs;
    logic               push, serr_set;
    logic [RX_WORD-1:0] push_word;

    tdmrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk_raw (bclk_in),
        .fclk_raw (fclk_in),
        .sd_raw   (sdata_in),
        .inv_b    (cfg_bclk_inv),
        .inv_f    (cfg_fclk_inv),
        .bit_stb  (bit_stb),
        .bit_sd   (bit_sd),
        .bit_fs   (bit_fs)
    );

    tdmrx_framer #(.MAX_SLOTS(MAX_SLOTS)) u_framer (
        .clk            (clk),
        .rst_n          (rst_n),
        .bit_stb        (bit_stb),
        .bit_sd         (bit_sd),
        .bit_fs         (bit_fs),
        .cfg_fmt        (cfg_fmt),
        .cfg_depth      (cfg_depth),
        .cfg_wide       (cfg_wide_slot),
        .cfg_nslot      (cfg_nslot),
        .cfg_slot_en    (cfg_slot_en),
        .cfg_start_rise (cfg_start_rise),
        .push           (push),
        .push_word      (push_word),
        .serr_set       (serr_set)
    );

    tdmrx_fifo #(.DEPTH(FIFO_DEPTH), .W(RX_WORD)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (push),
        .wdata   (push_word),
        .rd      (rd_en),
        .ovf_clr (ovf_clr),
        .level   (cfg_level),
        .rdata   (rd_data),
        .valid   (rd_valid),
        .above   (lvl_above),
        .full    (fifo_full),
        .ovf     (ovf_flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sync_err <= 1'b0;
        else if (sync_clr) sync_err <= 1'b0;
        else if (serr_set) sync_err <= 1'b1;
    end

    // R9: sync error stays until cleared
    a_r9_serr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_err && !sync_clr) |=> sync_err);

endmodule

// File: tb/test_tdm_rx_deser.sv
`timescale 1ns/1ps
module test_tdm_rx_deser;

    localparam int FD  = 8;
    localparam int LVW = $clog2(FD + 1);

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        bclk_raw = 1'b0, fclk_raw = 1'b0, sd = 1'b0;
    logic [1:0]  c_fmt = 2'd1, c_depth = 2'd0;
    logic        c_wide = 1'b0, c_binv = 1'b0, c_finv = 1'b0, c_rise = 1'b1;
    logic [3:0]  c_ns = 4'd2;
    logic [7:0]  c_mask = 8'h03;
    logic [LVW-1:0] c_level = '0;
    logic        rd_en = 1'b0, ovf_clr = 1'b0, sync_clr = 1'b0;
    logic [31:0] rd_data;
    logic        rd_valid, lvl_above, fifo_full, ovf_flag, sync_err;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] q[$];
    logic m_ovf = 1'b0, m_serr = 1'b0;

    tdm_rx_deser #(.MAX_SLOTS(8), .FIFO_DEPTH(FD)) i_tdm_rx_deser (
        .clk(clk), .rst_n(rst_n), .bclk_in(bclk_raw), .fclk_in(fclk_raw),
        .sdata_in(sd), .cfg_fmt(c_fmt), .cfg_depth(c_depth),
        .cfg_wide_slot(c_wide), .cfg_nslot(c_ns), .cfg_slot_en(c_mask),
        .cfg_bclk_inv(c_binv), .cfg_fclk_inv(c_finv),
        .cfg_start_rise(c_rise), .cfg_level(c_level), .rd_en(rd_en),
        .ovf_clr(ovf_clr), .sync_clr(sync_clr), .rd_data(rd_data),
        .rd_valid(rd_valid), .lvl_above(lvl_above), .fifo_full(fifo_full),
        .ovf_flag(ovf_flag), .sync_err(sync_err)
    );

    function automatic int slot_bits();
        return c_wide ? 32 : 16;
    endfunction

    function automatic int dep_bits();
        int d;
        d = (c_depth == 2'd0) ? 16 : (c_depth == 2'd1) ? 24 : 32;
        if (d > slot_bits()) d = slot_bits();
        return d;
    endfunction

    function automatic logic [31:0] expw(input logic [31:0] v);
        int L, d;
        logic [63:0] s;
        L = slot_bits();
        d = dep_bits();
        if (c_fmt == 2'd2) s = {32'd0, v} & ((64'd1 << d) - 64'd1);
        else               s = {32'd0, v} >> (L - d);
        s = s << (32 - d);
        return s[31:0];
    endfunction

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", rq, what, act, exp, $time);
        end
    endtask

    task automatic cmp(input string rq);
        chk(rq, "rd_valid", 32'(rd_valid), 32'(q.size() > 0));
        if (q.size() > 0) chk(rq, "rd_data", rd_data, q[0]);
        chk("R7", "lvl_above", 32'(lvl_above), 32'(q.size() > int'(c_level)));
        chk("R7", "fifo_full", 32'(fifo_full), 32'(q.size() == FD));
        chk("R8", "ovf_flag", 32'(ovf_flag), 32'(m_ovf));
        chk("R9", "sync_err", 32'(sync_err), 32'(m_serr));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bclk_raw = c_binv;
        fclk_raw = c_finv ^ ~c_rise;
        sd = 1'b0;
        q.delete();
        m_ovf = 1'b0;
        m_serr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic tx_bit(input logic d, input logic lvl, input logic ex, input logic [31:0] w,
                          input logic se, input string rq);
        @(negedge clk);
        bclk_raw = c_binv;
        sd = d;
        fclk_raw = lvl ^ c_finv;
        repeat (5) @(negedge clk);
        @(negedge clk);
        bclk_raw = ~c_binv;
        repeat (5) @(negedge clk);
        if (ex) begin
            if (q.size() < FD) q.push_back(w);
            else m_ovf = 1'b1;
        end
        if (se) m_serr = 1'b1;
        cmp(rq);
    endtask

    // builds a stream from the frame shape and expected words, then sends it
    task automatic play(input int pre, input int nfr, input int trunc_fr, input int trunc_k, input string rq);
        logic qd[$], qa[$], qe[$], qs[$];
        logic [31:0] qw[$];
        int L, T, K;
        logic lead, serr_next;
        logic [31:0] v;
        L = slot_bits();
        T = int'(c_ns) * L;
        lead = (c_fmt == 2'd0) || (c_fmt == 2'd3);
        serr_next = 1'b0;
        for (int p = 0; p < pre; p++) begin
            qd.push_back(1'($urandom)); qa.push_back(1'b0); qe.push_back(1'b0);
            qw.push_back(32'd0); qs.push_back(1'b0);
        end
        for (int f = 0; f < nfr; f++) begin
            K = (f == trunc_fr) ? trunc_k : T;
            for (int s = 0; s < int'(c_ns); s++) begin
                v = (L == 32) ? $urandom : ($urandom & 32'h0000_FFFF);
                for (int b = 0; b < L; b++) begin
                    int i;
                    i = s * L + b;
                    if (i < K) begin
                        qd.push_back(v[L-1-b]);
                        qa.push_back(((c_fmt == 2'd3) ? (i == 0) : (i < T / 2)) && (K == T || i < K - 1));
                        qe.push_back((b == L - 1) && c_mask[s]);
                        qw.push_back(expw(v));
                        qs.push_back(serr_next && (i == 0));
                    end
                end
            end
            serr_next = (f == trunc_fr);
        end
        for (int k = 0; k < qd.size(); k++) begin
            logic act;
            if (lead) act = (k + 1 < qd.size()) ? qa[k+1] : 1'b0;
            else      act = qa[k];
            tx_bit(qd[k], act ? c_rise : ~c_rise, qe[k], qw[k], qs[k], rq);
        end
    endtask

    task automatic pop_one(input string rq);
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        if (q.size() > 0) void'(q.pop_front());
        @(negedge clk);
        cmp(rq);
    endtask

    task automatic drain(input string rq);
        cmp(rq);
        while (q.size() > 0) pop_one(rq);
    endtask

    task automatic cfg(input logic [1:0] fmt, input logic [1:0] dep, input logic wide,
                       input logic [3:0] ns, input logic [7:0] mask, input logic rise,
                       input logic binv, input logic finv, input logic [LVW-1:0] lvl);
        c_fmt = fmt; c_depth = dep; c_wide = wide; c_ns = ns; c_mask = mask;
        c_rise = rise; c_binv = binv; c_finv = finv; c_level = lvl;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        cfg(2'd1, 2'd0, 1'b0, 4'd2, 8'h03, 1'b1, 1'b0, 1'b0, LVW'(0));
        do_reset();
        cmp("R1");

        // R3 R10: Philips, falling edge start, 32-bit slots, 16-bit depth
        cfg(2'd0, 2'd0, 1'b1, 4'd2, 8'h03, 1'b0, 1'b0, 1'b0, LVW'(2));
        do_reset();
        play(3, 3, -1, 0, "R3");
        drain("R3");

        // R2 R11: left-justified with a long noisy preamble
        cfg(2'd1, 2'd0, 1'b0, 4'd2, 8'h03, 1'b1, 1'b0, 1'b0, LVW'(1));
        do_reset();
        play(20, 3, -1, 0, "R11");
        drain("R2");

        // R4: right-justified 24-bit samples in 32-bit slots
        cfg(2'd2, 2'd1, 1'b1, 4'd2, 8'h03, 1'b1, 1'b0, 1'b0, LVW'(3));
        do_reset();
        play(3, 3, -1, 0, "R4");
        drain("R4");

        // R3 R5 R6: PCM, 8 slots, sparse mask, depth code clamped to 16
        cfg(2'd3, 2'd2, 1'b0, 4'd8, 8'hA5, 1'b1, 1'b0, 1'b0, LVW'(4));
        do_reset();
        play(3, 2, -1, 0, "R6");
        drain("R5");

        // R7 R8: overflow with 4-slot TDM, clear, empty read, continuation
        cfg(2'd1, 2'd2, 1'b1, 4'd4, 8'h0F, 1'b1, 1'b0, 1'b0, LVW'(5));
        do_reset();
        play(2, 3, -1, 0, "R8");
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0; m_ovf = 1'b0;
        @(negedge clk); cmp("R8");
        drain("R7");
        pop_one("R7");
        play(0, 1, -1, 0, "R7");
        drain("R7");

        // R9: truncated frame followed by an early edge
        cfg(2'd1, 2'd0, 1'b0, 4'd2, 8'h03, 1'b1, 1'b0, 1'b0, LVW'(7));
        do_reset();
        play(3, 3, 1, 8, "R9");
        drain("R9");
        @(negedge clk); sync_clr = 1'b1;
        @(negedge clk); sync_clr = 1'b0; m_serr = 1'b0;
        @(negedge clk); cmp("R9");

        // R10: both clocks inverted, only slot 1 enabled
        cfg(2'd1, 2'd2, 1'b1, 4'd2, 8'h02, 1'b1, 1'b1, 1'b1, LVW'(0));
        do_reset();
        play(3, 3, -1, 0, "R10");
        drain("R10");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule